// File: doc/BRIEF.md
# Dual-Map Register Renamer with Selective Merge

This block renames architectural registers to physical registers through two map tables. The speculative map serves the normal front end. A second map, the repair map, serves misprediction recovery. A bank of per-branch snapshots records the speculative map whenever a branch asks for one.

When a branch turns out to be mispredicted, its snapshot is loaded into the repair map only. The speculative map keeps running for younger work. The correct control-dependent instructions are renamed against the repair map, and so are the duplicated instructions that must execute again. Instructions that do not depend on the branch are not replayed. Every repair-map write marks its architectural register dirty. A single merge command then copies only the dirty entries into the speculative map in one cycle.

Both maps have their own rename port, and both ports may rename in the same cycle. A simple FIFO free list supplies the destination registers. Released registers are pushed back into that free list.

Top module: `dual_map_renamer`

## Requirements
- R1: After reset, both maps hold the identity mapping (architectural register i maps to physical register i). No snapshot slot is live. The free list holds physical registers NUM_ARCH up to NUM_PHYS-1, in ascending order.
- R2: `spec_src_phys` shows the speculative-map entry of `spec_src` combinationally, with no bypass from a write in the same cycle. A granted speculative rename writes its new physical register to `spec_dst` in the speculative map at the next clock edge.
- R3: The free list hands out registers in FIFO order. The speculative port is served first, and the repair port takes the next entry after it. A port is granted only if enough entries remain for it. A register released with `rel_vld` is appended at the tail of the free list.
- R4: A snapshot request takes the lowest-numbered slot that is not live and reports that slot on `ckpt_slot`. The snapshot stores the speculative map as it stood at the start of that cycle, so a same-cycle speculative write is not included. `ckpt_drop_vld` makes a slot free again.
- R5: A snapshot request while every slot is live raises `ckpt_stall` and gives no grant. No slot and no stored snapshot changes.
- R6: `mp_vld` loads the snapshot of slot `mp_slot` into the repair map at the next edge and clears every dirty bit. The speculative map is left untouched.
- R7: `rep_src_phys` shows the repair-map entry of `rep_src`. A granted repair rename writes the repair map and marks that register dirty. No repair rename is granted in a cycle that carries `mp_vld` or `merge_vld`.
- R8: Speculative and repair renames in the same cycle each update only their own map.
- R9: `merge_vld` copies every dirty repair-map entry into the speculative map at the next edge and clears all dirty bits. Entries that are not dirty are left as they are.
- R10: When a merge and a speculative rename write the same register in the same cycle, the merged value wins. A same-cycle speculative write to a register that is not dirty is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_vld | input | 1 | Speculative rename request |
| spec_src | input | AW | Source register read through the speculative map |
| spec_dst | input | AW | Destination register for the speculative rename |
| spec_gnt | output | 1 | Speculative rename granted |
| spec_src_phys | output | PW | Speculative-map entry of `spec_src` |
| spec_dst_phys | output | PW | Physical register allocated to the speculative rename |
| rep_vld | input | 1 | Repair rename request |
| rep_src | input | AW | Source register read through the repair map |
| rep_dst | input | AW | Destination register for the repair rename |
| rep_gnt | output | 1 | Repair rename granted |
| rep_src_phys | output | PW | Repair-map entry of `rep_src` |
| rep_dst_phys | output | PW | Physical register allocated to the repair rename |
| rel_vld | input | 1 | Return a physical register to the free list |
| rel_phys | input | PW | Register being returned |
| ckpt_take | input | 1 | Request a snapshot of the speculative map |
| ckpt_gnt | output | 1 | Snapshot taken |
| ckpt_slot | output | SW | Slot that received the snapshot |
| ckpt_stall | output | 1 | Snapshot refused because all slots are live |
| ckpt_drop_vld | input | 1 | Free a snapshot slot |
| ckpt_drop_slot | input | SW | Slot to free |
| mp_vld | input | 1 | Misprediction: load a snapshot into the repair map |
| mp_slot | input | SW | Slot to load |
| merge_vld | input | 1 | Copy the dirty repair entries into the speculative map |

## Verification
A wrong map entry shows up on the matching `*_src_phys` port as soon as that register is read, one edge after the bad write. The bench therefore sweeps both read ports across every architectural register after each recovery phase. A damaged snapshot stays hidden until that slot is loaded by a misprediction, so the tests load slots that have been live across stalls and drops. A fault in free-list order or count shows up on the next allocation, either as a wrong `*_dst_phys` value or as a grant that is missing or extra.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  typedef int unsigned idx_t;

  // Modular advance of a ring index.
  function automatic idx_t ring_add(idx_t p, idx_t k, idx_t depth);
    return (p + k) % depth;
  endfunction

  // Lowest index below n whose bit is clear; -1 if none is clear.
  function automatic int lowest_clear(logic [63:0] v, idx_t n);
    int r;
    r = -1;
    for (int i = 63; i >= 0; i--) begin
      if (idx_t'(i) < n && !v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/rrm_free_fifo.sv
module rrm_free_fifo #(
  parameter int NUM_PHYS = 256,
  parameter int NUM_ARCH = 32,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_a,
  input  logic          want_b,
  output logic          gnt_a,
  output logic          gnt_b,
  output logic [PW-1:0] phys_a,
  output logic [PW-1:0] phys_b,
  input  logic          push_vld,
  input  logic [PW-1:0] push_phys
);
  import rrm_pkg::*;

  localparam int INIT_CNT = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] slots [NUM_PHYS];
  logic [PW-1:0] head_q, tail_q, head_nx1;
  logic [CW-1:0] cnt_q;
  logic [1:0]    pops;

  assign head_nx1 = PW'(ring_add(idx_t'(head_q), 1, NUM_PHYS));
  assign gnt_a    = want_a && (cnt_q >= CW'(1));
  assign gnt_b    = want_b && (gnt_a ? (cnt_q >= CW'(2)) : (cnt_q >= CW'(1)));
  assign phys_a   = slots[head_q];
  assign phys_b   = gnt_a ? slots[head_nx1] : slots[head_q];
  assign pops     = 2'(gnt_a) + 2'(gnt_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slots[i] <= (i < INIT_CNT) ? PW'(i + NUM_ARCH) : '0;
      head_q <= '0;
      tail_q <= PW'(ring_add(INIT_CNT, 0, NUM_PHYS));
      cnt_q  <= CW'(INIT_CNT);
    end else begin
      head_q <= PW'(ring_add(idx_t'(head_q), idx_t'(pops), NUM_PHYS));
      if (push_vld) begin
        slots[tail_q] <= push_phys;
        tail_q        <= PW'(ring_add(idx_t'(tail_q), 1, NUM_PHYS));
      end
      cnt_q <= cnt_q + CW'(push_vld) - CW'(pops);
    end
  end

  AST_FREE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && pops == 2'd0) |-> (cnt_q < CW'(NUM_PHYS))); // R3

  AST_FREE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_vld && !want_a && !want_b) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/rrm_ckpt_store.sv
module rrm_ckpt_store #(
  parameter int NUM_CKPT = 16,
  parameter int NUM_ARCH = 32,
  parameter int PW       = 8,
  localparam int SW = $clog2(NUM_CKPT),
  localparam int MW = NUM_ARCH * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [MW-1:0] snap_in,
  input  logic          drop_vld,
  input  logic [SW-1:0] drop_slot,
  input  logic [SW-1:0] rd_slot,
  output logic [MW-1:0] rd_data,
  output logic          gnt,
  output logic [SW-1:0] slot,
  output logic          stall
);
  import rrm_pkg::*;

  logic [NUM_CKPT-1:0] live_q;
  logic [MW-1:0]       snap_q [NUM_CKPT];
  logic                full;
  int                  free_idx;

  always_comb free_idx = lowest_clear(64'(live_q), NUM_CKPT);

  assign full    = &live_q;
  assign gnt     = take && !full;
  assign stall   = take && full;
  assign slot    = full ? '0 : SW'(free_idx);
  assign rd_data = snap_q[rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      if (drop_vld) live_q[drop_slot] <= 1'b0;
      if (gnt)      live_q[slot]      <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (gnt) snap_q[slot] <= snap_in;
  end

  AST_STALL_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !drop_vld) |=> (live_q == $past(live_q))); // R5

  AST_GRANT_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> !live_q[slot]); // R4

  for (genvar k = 0; k < NUM_CKPT; k++) begin : g_frozen
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q[k] && !(gnt && slot == SW'(k))) |=> (snap_q[k] == $past(snap_q[k]))); // R5
  end

endmodule

// File: rtl/rrm_map_pair.sv
module rrm_map_pair #(
  parameter int NUM_ARCH = 32,
  parameter int PW       = 8,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int MW = NUM_ARCH * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] spec_rd_idx,
  output logic [PW-1:0] spec_rd_phys,
  input  logic          spec_we,
  input  logic [AW-1:0] spec_wr_idx,
  input  logic [PW-1:0] spec_wr_phys,
  output logic [MW-1:0] spec_flat,
  input  logic [AW-1:0] rep_rd_idx,
  output logic [PW-1:0] rep_rd_phys,
  input  logic          rep_we,
  input  logic [AW-1:0] rep_wr_idx,
  input  logic [PW-1:0] rep_wr_phys,
  input  logic          load_vld,
  input  logic [MW-1:0] load_flat,
  input  logic          merge_vld
);

  logic [PW-1:0]       spec_q [NUM_ARCH];
  logic [PW-1:0]       rep_q  [NUM_ARCH];
  logic [NUM_ARCH-1:0] dirty_q;

  assign spec_rd_phys = spec_q[spec_rd_idx];
  assign rep_rd_phys  = rep_q[rep_rd_idx];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_pack
    assign spec_flat[g*PW +: PW] = spec_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        spec_q[i] <= PW'(i);
        rep_q[i]  <= PW'(i);
      end
      dirty_q <= '0;
    end else begin
      if (spec_we) spec_q[spec_wr_idx] <= spec_wr_phys;
      if (merge_vld) begin
        for (int i = 0; i < NUM_ARCH; i++)
          if (dirty_q[i]) spec_q[i] <= rep_q[i];
      end
      if (load_vld) begin
        for (int i = 0; i < NUM_ARCH; i++)
          rep_q[i] <= load_flat[i*PW +: PW];
        dirty_q <= '0;
      end else if (merge_vld) begin
        dirty_q <= '0;
      end else if (rep_we) begin
        rep_q[rep_wr_idx]   <= rep_wr_phys;
        dirty_q[rep_wr_idx] <= 1'b1;
      end
    end
  end

  AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_we && !load_vld && !merge_vld) |=> dirty_q[$past(rep_wr_idx)]); // R7

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_chk
    AST_MERGE_TAKES_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_vld && dirty_q[g]) |=> (spec_q[g] == $past(rep_q[g]))); // R10
    AST_MERGE_SKIPS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_vld && !dirty_q[g] && !(spec_we && spec_wr_idx == AW'(g)))
        |=> (spec_q[g] == $past(spec_q[g]))); // R9
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      load_vld |=> (rep_q[g] == $past(load_flat[g*PW +: PW]))); // R6
    AST_LOAD_SPARES_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      (load_vld && !merge_vld && !(spec_we && spec_wr_idx == AW'(g)))
        |=> (spec_q[g] == $past(spec_q[g]))); // R6
  end

endmodule

// File: rtl/dual_map_renamer.sv
module dual_map_renamer #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 256,
  parameter int NUM_CKPT = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int SW = $clog2(NUM_CKPT),
  localparam int MW = NUM_ARCH * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_vld,
  input  logic [AW-1:0] spec_src,
  input  logic [AW-1:0] spec_dst,
  output logic          spec_gnt,
  output logic [PW-1:0] spec_src_phys,
  output logic [PW-1:0] spec_dst_phys,
  input  logic          rep_vld,
  input  logic [AW-1:0] rep_src,
  input  logic [AW-1:0] rep_dst,
  output logic          rep_gnt,
  output logic [PW-1:0] rep_src_phys,
  output logic [PW-1:0] rep_dst_phys,
  input  logic          rel_vld,
  input  logic [PW-1:0] rel_phys,
  input  logic          ckpt_take,
  output logic          ckpt_gnt,
  output logic [SW-1:0] ckpt_slot,
  output logic          ckpt_stall,
  input  logic          ckpt_drop_vld,
  input  logic [SW-1:0] ckpt_drop_slot,
  input  logic          mp_vld,
  input  logic [SW-1:0] mp_slot,
  input  logic          merge_vld
);

  logic          rep_want;
  logic [MW-1:0] spec_snapshot;
  logic [MW-1:0] mp_snapshot;

  // Repair port yields to the two map-wide commands.
  assign rep_want = rep_vld && !mp_vld && !merge_vld;

  rrm_free_fifo #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) i_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_a    (spec_vld),
    .want_b    (rep_want),
    .gnt_a     (spec_gnt),
    .gnt_b     (rep_gnt),
    .phys_a    (spec_dst_phys),
    .phys_b    (rep_dst_phys),
    .push_vld  (rel_vld),
    .push_phys (rel_phys)
  );

  rrm_ckpt_store #(.NUM_CKPT(NUM_CKPT), .NUM_ARCH(NUM_ARCH), .PW(PW)) i_ckpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ckpt_take),
    .snap_in   (spec_snapshot),
    .drop_vld  (ckpt_drop_vld),
    .drop_slot (ckpt_drop_slot),
    .rd_slot   (mp_slot),
    .rd_data   (mp_snapshot),
    .gnt       (ckpt_gnt),
    .slot      (ckpt_slot),
    .stall     (ckpt_stall)
  );

  rrm_map_pair #(.NUM_ARCH(NUM_ARCH), .PW(PW)) i_maps (
    .clk          (clk),
    .rst_n        (rst_n),
    .spec_rd_idx  (spec_src),
    .spec_rd_phys (spec_src_phys),
    .spec_we      (spec_gnt),
    .spec_wr_idx  (spec_dst),
    .spec_wr_phys (spec_dst_phys),
    .spec_flat    (spec_snapshot),
    .rep_rd_idx   (rep_src),
    .rep_rd_phys  (rep_src_phys),
    .rep_we       (rep_gnt),
    .rep_wr_idx   (rep_dst),
    .rep_wr_phys  (rep_dst_phys),
    .load_vld     (mp_vld),
    .load_flat    (mp_snapshot),
    .merge_vld    (merge_vld)
  );

  AST_DISTINCT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_gnt && rep_gnt) |-> (spec_dst_phys != rep_dst_phys)); // R3

  AST_SPEC_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_gnt && !merge_vld && spec_src == spec_dst) |=> (spec_src_phys == $past(spec_dst_phys)) || !$stable(spec_src)); // R2

endmodule

// File: tb/test_dual_map_renamer.sv
module test_dual_map_renamer;
  localparam int A = 8;
  localparam int P = 32;
  localparam int C = 4;
  localparam int AW = $clog2(A);
  localparam int PW = $clog2(P);
  localparam int SW = $clog2(C);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_vld = 0, rep_vld = 0, rel_vld = 0, ckpt_take = 0;
  logic ckpt_drop_vld = 0, mp_vld = 0, merge_vld = 0;
  logic [AW-1:0] spec_src = 0, spec_dst = 0, rep_src = 0, rep_dst = 0;
  logic [PW-1:0] rel_phys = 0;
  logic [SW-1:0] ckpt_drop_slot = 0, mp_slot = 0;
  logic spec_gnt, rep_gnt, ckpt_gnt, ckpt_stall;
  logic [PW-1:0] spec_src_phys, spec_dst_phys, rep_src_phys, rep_dst_phys;
  logic [SW-1:0] ckpt_slot;

  always #2 clk = ~clk;

  dual_map_renamer #(.NUM_ARCH(A), .NUM_PHYS(P), .NUM_CKPT(C)) i_dual_map_renamer (
    .clk(clk), .rst_n(rst_n),
    .spec_vld(spec_vld), .spec_src(spec_src), .spec_dst(spec_dst),
    .spec_gnt(spec_gnt), .spec_src_phys(spec_src_phys), .spec_dst_phys(spec_dst_phys),
    .rep_vld(rep_vld), .rep_src(rep_src), .rep_dst(rep_dst),
    .rep_gnt(rep_gnt), .rep_src_phys(rep_src_phys), .rep_dst_phys(rep_dst_phys),
    .rel_vld(rel_vld), .rel_phys(rel_phys),
    .ckpt_take(ckpt_take), .ckpt_gnt(ckpt_gnt), .ckpt_slot(ckpt_slot), .ckpt_stall(ckpt_stall),
    .ckpt_drop_vld(ckpt_drop_vld), .ckpt_drop_slot(ckpt_drop_slot),
    .mp_vld(mp_vld), .mp_slot(mp_slot), .merge_vld(merge_vld)
  );

  // Reference state, built from the requirements.
  int m_spec [A];
  int m_rep [A];
  bit m_dirty [A];
  int fl [P];
  int fh, ft, fc;
  bit c_live [C];
  int c_snap [C][A];

  int n_cmp = 0, n_bad = 0;
  string phase = "R1 reset";
  bit done = 0;

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s]: got %0d expected %0d", tag, phase, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < A; i++) begin m_spec[i] = i; m_rep[i] = i; m_dirty[i] = 0; end
    for (int i = 0; i < P; i++) fl[i] = (i < P - A) ? i + A : 0;
    fh = 0; ft = P - A; fc = P - A;
    for (int k = 0; k < C; k++) c_live[k] = 0;
  endtask

  task automatic step(input bit sv, input int ss, input int sd,
                      input bit rv, input int rs, input int rd,
                      input bit rl, input int rp,
                      input bit ct, input bit cd, input int cds,
                      input bit mp, input int mps, input bit mg);
    int sg, rg, sphys, rphys, slot, nspec[A];
    bit full, cg;
    spec_vld = sv; spec_src = AW'(ss); spec_dst = AW'(sd);
    rep_vld = rv; rep_src = AW'(rs); rep_dst = AW'(rd);
    rel_vld = rl; rel_phys = PW'(rp);
    ckpt_take = ct; ckpt_drop_vld = cd; ckpt_drop_slot = SW'(cds);
    mp_vld = mp; mp_slot = SW'(mps); merge_vld = mg;
    #1;
    sg = (sv && fc >= 1) ? 1 : 0;
    rg = (rv && !mp && !mg && fc >= 1 + sg) ? 1 : 0;
    sphys = fl[fh];
    rphys = fl[(fh + sg) % P];
    full = 1; slot = 0;
    for (int k = C - 1; k >= 0; k--) if (!c_live[k]) begin full = 0; slot = k; end
    cg = ct && !full;
    chk("R2 spec_src_phys", int'(spec_src_phys), m_spec[ss]);
    chk("R7 rep_src_phys", int'(rep_src_phys), m_rep[rs]);
    chk("R3 spec_gnt", int'(spec_gnt), sg);
    chk("R3 rep_gnt", int'(rep_gnt), rg);
    if (sg == 1) chk("R3 spec_dst_phys", int'(spec_dst_phys), sphys);
    if (rg == 1) chk("R3 rep_dst_phys", int'(rep_dst_phys), rphys);
    if (ct) begin
      chk("R5 ckpt_stall", int'(ckpt_stall), int'(full));
      chk("R4 ckpt_gnt", int'(ckpt_gnt), int'(cg));
      if (cg) chk("R4 ckpt_slot", int'(ckpt_slot), slot);
    end
    @(posedge clk);
    if (cg) for (int i = 0; i < A; i++) c_snap[slot][i] = m_spec[i];
    for (int i = 0; i < A; i++) nspec[i] = m_spec[i];
    if (sg == 1) nspec[sd] = sphys;
    if (mg) for (int i = 0; i < A; i++) if (m_dirty[i]) nspec[i] = m_rep[i];
    if (mp) begin
      for (int i = 0; i < A; i++) begin m_rep[i] = c_snap[mps][i]; m_dirty[i] = 0; end
    end else if (mg) begin
      for (int i = 0; i < A; i++) m_dirty[i] = 0;
    end else if (rg == 1) begin
      m_rep[rd] = rphys; m_dirty[rd] = 1;
    end
    for (int i = 0; i < A; i++) m_spec[i] = nspec[i];
    if (cd) c_live[cds] = 0;
    if (cg) c_live[slot] = 1;
    fh = (fh + sg + rg) % P;
    if (rl) begin fl[ft] = rp; ft = (ft + 1) % P; end
    fc = fc + (rl ? 1 : 0) - sg - rg;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0,0,0, 0,0,0, 0,0, 0,0,0, 0,0,0);
  endtask

  task automatic sweep();
    for (int a = 0; a < A; a++) step(0,a,0, 0,a,0, 0,0, 0,0,0, 0,0,0);
  endtask

  int lfsr = 32'h1ACE5;

  function automatic int nxt(int v);
    return (v >>> 1) ^ ((v & 1) != 0 ? 32'h0080_0057 : 0);
  endfunction

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset state";
    sweep();

    phase = "R2 R3 spec renames";
    for (int i = 0; i < 6; i++) step(1,(i+7)%A,i, 0,0,0, 0,0, 0,0,0, 0,0,0);
    sweep();

    phase = "R4 snapshot with same-cycle write";
    for (int i = 0; i < 4; i++) begin
      step(1,i,(i*3)%A, 0,0,0, 0,0, 1,0,0, 0,0,0);
      step(1,i,(i+2)%A, 0,0,0, 0,0, 0,0,0, 0,0,0);
    end
    phase = "R5 all slots live";
    step(1,1,1, 0,0,0, 0,0, 1,0,0, 0,0,0);
    step(0,0,0, 0,0,0, 0,0, 1,0,0, 0,0,0);
    phase = "R4 drop then retake";
    step(0,0,0, 0,0,0, 0,0, 0,1,2, 0,0,0);
    step(1,5,5, 0,0,0, 0,0, 1,0,0, 0,0,0);

    phase = "R6 mispredict load";
    step(1,2,6, 0,0,0, 0,0, 0,0,0, 1,1,0);
    sweep();
    phase = "R6 reload of slot kept across stall";
    step(0,0,0, 0,0,0, 0,0, 0,0,0, 1,3,0);
    sweep();

    phase = "R7 R8 repair with concurrent spec";
    for (int i = 0; i < 5; i++) step(1,i,(i+4)%A, 1,i,(i*5)%A, 0,0, 0,0,0, 0,0,0);
    step(0,0,0, 1,1,1, 0,0, 0,0,0, 1,0,0);
    sweep();
    step(0,0,0, 1,2,2, 0,0, 0,0,0, 0,0,0);
    step(0,0,0, 1,3,3, 0,0, 0,0,0, 0,0,1);

    phase = "R9 merge of dirty entries";
    sweep();
    step(0,0,0, 1,4,4, 0,0, 0,0,0, 0,0,0);
    step(0,0,0, 0,0,0, 0,0, 0,0,0, 0,0,1);
    sweep();

    phase = "R10 merge beats spec write";
    step(0,0,0, 1,3,3, 0,0, 0,0,0, 0,0,0);
    step(1,0,3, 0,0,0, 0,0, 0,0,0, 0,0,1);
    step(1,0,5, 0,0,0, 0,0, 0,0,0, 0,0,1);
    sweep();

    phase = "R3 free list exhaustion";
    while (fc > 0) step(1,0,fc%A, 1,0,(fc+1)%A, 0,0, 0,0,0, 0,0,0);
    step(1,0,1, 1,0,2, 0,0, 0,0,0, 0,0,0);
    step(1,0,1, 1,0,2, 1,9, 0,0,0, 0,0,0);
    step(1,0,1, 1,0,2, 1,11, 0,0,0, 0,0,0);
    step(1,0,1, 1,0,2, 0,0, 0,0,0, 0,0,0);
    sweep();

    phase = "R8 mixed traffic";
    for (int n = 0; n < 3000; n++) begin
      int ms;
      bit mp_b, rl_b;
      lfsr = nxt(lfsr);
      ms = (lfsr >> 12) % C;
      mp_b = ((lfsr >> 3) % 13 == 0) && c_live[ms];
      rl_b = (lfsr >> 4) % 3 != 0 && fc < P - 3;
      step((lfsr >> 1) % 2 == 1, (lfsr >> 5) % A, (lfsr >> 8) % A,
           (lfsr >> 2) % 2 == 1, (lfsr >> 11) % A, (lfsr >> 14) % A,
           rl_b, (lfsr >> 17) % P,
           (lfsr >> 20) % 4 == 0, (lfsr >> 22) % 5 == 0, (lfsr >> 24) % C,
           mp_b, ms, (lfsr >> 26) % 11 == 0);
      if (n % 500 == 499) sweep();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog [%s]: got 0 expected 1 (run did not complete)", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule